// File: doc/BRIEF.md
# Event-Selectable Cache Performance Counter Bank

This block holds four 64-bit performance counters for a cache. Each counter is steered to one event source by an 8-bit selection code and carries a clear-on-read option. Both are written through a simple configuration port. Every clock cycle the cache presents a set of event inputs. Some are single-bit pulses. Others are small counts, such as how many fill entries are valid or waiting, or how many banks of a quadrant are busy. Each counter adds the amount chosen by its code.

Software reads a counter by raising a read request with an index. The value comes back one cycle later on a 64-bit data port. If the counter's clear-on-read option is set, the read also restarts the count. An increment that lands in the same cycle as the read is kept, so no events are lost. Sums wrap modulo 2^64.

Top module: `perf_counter_bank`

## Requirements
- R1: The four counters are independent. A configuration write with `cfgWe`=1 sets only counter `cfgIdx`, loading its selection code from `cfgSel` and its clear-on-read option from `cfgClr`. The new settings govern increments from the cycle after the write.
- R2: After reset all counters read 0, every code is 0, every clear-on-read option is off, and `rdValid` is 0.
- R3: A read has a latency of one cycle. When `rdEn`=1 with index `rdIdx` in cycle t, then in cycle t+1 `rdValid`=1 and `rdData` holds the counter value from before the edge that ends cycle t. That value includes every increment up to cycle t-1.
- R4: Code 0 counts nothing. Any code not defined in R5 to R8 also counts nothing, for example 99 or 133.
- R5: Code 1 adds 1 on every clock cycle.
- R6: Codes 2 to 7 add 1 in each cycle where `evPulse[code-2]` is high.
- R7: Codes 8, 9 and 10 add the 4-bit count `evOcc[4*j+3:4*j]` on each cycle, where j = code-8. The three fields are occupancy of valid entries, entries waiting on other entries, and entries waiting on victim space.
- R8: Code 128+16*q+k, with q from 0 to 3, selects activity in quadrant q. When k=0 it adds `quadIdxBusy[q]`. When k=1 it adds `quadRdBusy[q]`. When k=2 it adds the 3-bit bank count `quadBanks[3*q+2:3*q]`, a value from 0 to 4. When k=3 it adds the 3-bit write-data count `quadWdat[3*q+2:3*q]`, also a value from 0 to 4.
- R9: A read of a counter whose clear-on-read option is set returns the old value, and the counter then holds only the increment of the read cycle. A read with the option off leaves the counter running unchanged.
- R10: Writing a new code or a new clear-on-read option does not change the counter's current value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgIdx | input | 2 | Counter selected for configuration |
| cfgSel | input | 8 | Event selection code |
| cfgClr | input | 1 | Clear-on-read option |
| rdEn | input | 1 | Read request |
| rdIdx | input | 2 | Counter to read |
| rdValid | output | 1 | Read data valid, one cycle after `rdEn` |
| rdData | output | 64 | Counter value returned by the read |
| evPulse | input | 6 | Single-bit event pulses (codes 2 to 7) |
| evOcc | input | 12 | Three 4-bit occupancy counts (codes 8 to 10) |
| quadIdxBusy | input | 4 | Index bus busy, one bit per quadrant |
| quadRdBusy | input | 4 | Read data bus busy, one bit per quadrant |
| quadBanks | input | 12 | Banks in use, 3 bits per quadrant |
| quadWdat | input | 12 | Write-data flops in use, 3 bits per quadrant |

## Verification
The assertions check the following on every cycle. Read data arrives one cycle after its request and matches the counter as it stood at the request. A counter on code 0 holds its value. A counter on code 1 steps by exactly one. A clear-on-read access to an idle counter leaves zero behind.

Some behaviours can only be shown by the bench's scenarios, which run against a reference model fed random event traffic. These are the mapping of each sparse code to its input field, the multi-valued occupancy and bank sums, the handling of undefined codes, the preservation of the count across reconfiguration, and the exact residue left by a clear-on-read that coincides with an increment.

// File: rtl/perf_counter_pkg.sv
package perf_counter_pkg;

  localparam int PcNumCtr   = 4;
  localparam int PcCntW     = 64;
  localparam int PcSelW     = 8;
  localparam int PcNumPulse = 6;
  localparam int PcNumOcc   = 3;
  localparam int PcOccW     = 4;
  localparam int PcNumQuad  = 4;
  localparam int PcQuadW    = 3;
  localparam int PcIdxW     = $clog2(PcNumCtr);
  localparam int PcIncW     = (PcOccW > PcQuadW) ? PcOccW : PcQuadW;

  // Event code map
  localparam int EvNone      = 0;
  localparam int EvCycle     = 1;
  localparam int EvPulseBase = 2;
  localparam int EvOccBase   = EvPulseBase + PcNumPulse;
  localparam int EvQuadBase  = 128;
  localparam int EvQuadStep  = 16;

  // Quadrant sub-event offsets
  localparam int QkIdxBus = 0;
  localparam int QkRdBus  = 1;
  localparam int QkBanks  = 2;
  localparam int QkWdat   = 3;

  typedef logic [PcNumCtr-1:0][PcSelW-1:0] selArray_t;
  typedef logic [PcNumCtr-1:0][PcCntW-1:0] cntArray_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic [PcNumCtr-1:0] clearNow;
    logic                rdNow;
    logic [PcIdxW-1:0]   rdSel;
  } pcStrobe_t;

endpackage

// File: rtl/perf_counter_ctrl.sv
module perf_counter_ctrl
  import perf_counter_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [PcIdxW-1:0] cfgIdx,
  input  logic [PcSelW-1:0] cfgSel,
  input  logic              cfgClr,
  input  logic              rdEn,
  input  logic [PcIdxW-1:0] rdIdx,
  output selArray_t         selQ,
  output pcStrobe_t         strobe
);

  logic [PcNumCtr-1:0] clrOnRdQ;

  for (genvar i = 0; i < PcNumCtr; i++) begin : g_cfg
    always_ff @(posedge clk) begin
      if (!rstN) begin
        selQ[i]     <= '0;
        clrOnRdQ[i] <= 1'b0;
      end else if (cfgWe && (cfgIdx == PcIdxW'(i))) begin
        selQ[i]     <= cfgSel;
        clrOnRdQ[i] <= cfgClr;
      end
    end

    assign strobe.clearNow[i] = rdEn && (rdIdx == PcIdxW'(i)) && clrOnRdQ[i];
  end

  assign strobe.rdNow = rdEn;
  assign strobe.rdSel = rdIdx;

endmodule

// File: rtl/perf_event_mux.sv
module perf_event_mux
  import perf_counter_pkg::*;
(
  input  logic [PcSelW-1:0]            sel,
  input  logic [PcNumPulse-1:0]        evPulse,
  input  logic [PcNumOcc*PcOccW-1:0]   evOcc,
  input  logic [PcNumQuad-1:0]         quadIdxBusy,
  input  logic [PcNumQuad-1:0]         quadRdBusy,
  input  logic [PcNumQuad*PcQuadW-1:0] quadBanks,
  input  logic [PcNumQuad*PcQuadW-1:0] quadWdat,
  output logic [PcIncW-1:0]            inc
);

  always_comb begin
    inc = '0;
    if (sel == PcSelW'(EvCycle)) begin
      inc = PcIncW'(1);
    end
    for (int j = 0; j < PcNumPulse; j++) begin
      if (sel == PcSelW'(EvPulseBase + j)) inc = PcIncW'(evPulse[j]);
    end
    for (int j = 0; j < PcNumOcc; j++) begin
      if (sel == PcSelW'(EvOccBase + j)) inc = PcIncW'(evOcc[j*PcOccW +: PcOccW]);
    end
    for (int q = 0; q < PcNumQuad; q++) begin
      if (sel == PcSelW'(EvQuadBase + EvQuadStep*q + QkIdxBus)) inc = PcIncW'(quadIdxBusy[q]);
      if (sel == PcSelW'(EvQuadBase + EvQuadStep*q + QkRdBus))  inc = PcIncW'(quadRdBusy[q]);
      if (sel == PcSelW'(EvQuadBase + EvQuadStep*q + QkBanks))  inc = PcIncW'(quadBanks[q*PcQuadW +: PcQuadW]);
      if (sel == PcSelW'(EvQuadBase + EvQuadStep*q + QkWdat))   inc = PcIncW'(quadWdat[q*PcQuadW +: PcQuadW]);
    end
  end

endmodule

// File: rtl/perf_counter_dp.sv
module perf_counter_dp
  import perf_counter_pkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  pcStrobe_t                    strobe,
  input  selArray_t                    selQ,
  input  logic [PcNumPulse-1:0]        evPulse,
  input  logic [PcNumOcc*PcOccW-1:0]   evOcc,
  input  logic [PcNumQuad-1:0]         quadIdxBusy,
  input  logic [PcNumQuad-1:0]         quadRdBusy,
  input  logic [PcNumQuad*PcQuadW-1:0] quadBanks,
  input  logic [PcNumQuad*PcQuadW-1:0] quadWdat,
  output cntArray_t                    cntQ,
  output logic                         rdValid,
  output logic [PcCntW-1:0]            rdData
);

  for (genvar i = 0; i < PcNumCtr; i++) begin : g_ctr
    logic [PcIncW-1:0] inc;

    perf_event_mux u_mux (
      .sel         (selQ[i]),
      .evPulse     (evPulse),
      .evOcc       (evOcc),
      .quadIdxBusy (quadIdxBusy),
      .quadRdBusy  (quadRdBusy),
      .quadBanks   (quadBanks),
      .quadWdat    (quadWdat),
      .inc         (inc)
    );

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cntQ[i] <= '0;
      end else if (strobe.clearNow[i]) begin
        cntQ[i] <= PcCntW'(inc);
      end else begin
        cntQ[i] <= cntQ[i] + PcCntW'(inc);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= strobe.rdNow;
      if (strobe.rdNow) rdData <= cntQ[strobe.rdSel];
    end
  end

endmodule

// File: rtl/perf_counter_bank.sv
module perf_counter_bank
  import perf_counter_pkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         cfgWe,
  input  logic [PcIdxW-1:0]            cfgIdx,
  input  logic [PcSelW-1:0]            cfgSel,
  input  logic                         cfgClr,
  input  logic                         rdEn,
  input  logic [PcIdxW-1:0]            rdIdx,
  output logic                         rdValid,
  output logic [PcCntW-1:0]            rdData,
  input  logic [PcNumPulse-1:0]        evPulse,
  input  logic [PcNumOcc*PcOccW-1:0]   evOcc,
  input  logic [PcNumQuad-1:0]         quadIdxBusy,
  input  logic [PcNumQuad-1:0]         quadRdBusy,
  input  logic [PcNumQuad*PcQuadW-1:0] quadBanks,
  input  logic [PcNumQuad*PcQuadW-1:0] quadWdat
);

  selArray_t selQ;
  cntArray_t cntQ;
  pcStrobe_t strobe;

  perf_counter_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .cfgWe  (cfgWe),
    .cfgIdx (cfgIdx),
    .cfgSel (cfgSel),
    .cfgClr (cfgClr),
    .rdEn   (rdEn),
    .rdIdx  (rdIdx),
    .selQ   (selQ),
    .strobe (strobe)
  );

  perf_counter_dp u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .selQ        (selQ),
    .evPulse     (evPulse),
    .evOcc       (evOcc),
    .quadIdxBusy (quadIdxBusy),
    .quadRdBusy  (quadRdBusy),
    .quadBanks   (quadBanks),
    .quadWdat    (quadWdat),
    .cntQ        (cntQ),
    .rdValid     (rdValid),
    .rdData      (rdData)
  );

endmodule

// File: rtl/perf_counter_bank_chk.sv
module perf_counter_bank_chk
  import perf_counter_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              rdEn,
  input logic [PcIdxW-1:0] rdIdx,
  input logic              rdValid,
  input logic [PcCntW-1:0] rdData,
  input selArray_t         selQ,
  input cntArray_t         cntQ,
  input pcStrobe_t         strobe
);

  p_read_latency_r3: assert property (@(posedge clk) disable iff (!rstN)
    rdValid == $past(rdEn));

  p_read_value_r3: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> (rdData == $past(cntQ[rdIdx])));

  for (genvar i = 0; i < PcNumCtr; i++) begin : g_chk
    p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
      (selQ[i] == PcSelW'(EvNone) && !strobe.clearNow[i]) |=> $stable(cntQ[i]));

    p_cycle_step_r5: assert property (@(posedge clk) disable iff (!rstN)
      (selQ[i] == PcSelW'(EvCycle) && !strobe.clearNow[i]) |=> (cntQ[i] == $past(cntQ[i]) + 64'd1));

    p_clear_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.clearNow[i] && selQ[i] == PcSelW'(EvNone)) |=> (cntQ[i] == '0));
  end

endmodule

bind perf_counter_bank perf_counter_bank_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .rdEn    (rdEn),
  .rdIdx   (rdIdx),
  .rdValid (rdValid),
  .rdData  (rdData),
  .selQ    (selQ),
  .cntQ    (cntQ),
  .strobe  (strobe)
);

// File: tb/tb_perf_counter_bank.sv
`timescale 1ns/1ps
module tb_perf_counter_bank;

  logic        clk = 1'b0;
  logic        rstN;
  logic        cfgWe;
  logic [1:0]  cfgIdx;
  logic [7:0]  cfgSel;
  logic        cfgClr;
  logic        rdEn;
  logic [1:0]  rdIdx;
  logic        rdValid;
  logic [63:0] rdData;
  logic [5:0]  evPulse;
  logic [11:0] evOcc;
  logic [3:0]  quadIdxBusy;
  logic [3:0]  quadRdBusy;
  logic [11:0] quadBanks;
  logic [11:0] quadWdat;

  always #2 clk = ~clk;

  perf_counter_bank dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgIdx(cfgIdx), .cfgSel(cfgSel),
    .cfgClr(cfgClr), .rdEn(rdEn), .rdIdx(rdIdx), .rdValid(rdValid), .rdData(rdData),
    .evPulse(evPulse), .evOcc(evOcc), .quadIdxBusy(quadIdxBusy), .quadRdBusy(quadRdBusy),
    .quadBanks(quadBanks), .quadWdat(quadWdat)
  );

  typedef struct {
    logic [63:0] val;
    string       req;
  } expItem_t;

  expItem_t    expQ[$];
  int          total = 0;
  int          bad = 0;
  logic        evRun = 1'b0;
  logic [63:0] cntM[4];
  logic [7:0]  selM[4];
  logic        clrM[4];

  // Reference increment, written from R4..R8
  function automatic logic [63:0] refInc(input logic [7:0] code);
    logic [63:0] r;
    int q;
    int k;
    r = 64'd0;
    if (code == 8'd1) r = 64'd1;
    else if (code >= 8'd2 && code <= 8'd7) r = {63'd0, evPulse[code - 8'd2]};
    else if (code >= 8'd8 && code <= 8'd10) r = 64'((evOcc >> (4 * (code - 8'd8))) & 12'hF);
    else if (code >= 8'd128 && code < 8'd192 && code[3:2] == 2'b00) begin
      q = int'(code[5:4]);
      k = int'(code[1:0]);
      case (k)
        0: r = {63'd0, quadIdxBusy[q]};
        1: r = {63'd0, quadRdBusy[q]};
        2: r = 64'((quadBanks >> (3 * q)) & 12'h7);
        default: r = 64'((quadWdat >> (3 * q)) & 12'h7);
      endcase
    end
    return r;
  endfunction

  // Reference model of counter state
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 4; i++) begin
        cntM[i] = 64'd0;
        selM[i] = 8'd0;
        clrM[i] = 1'b0;
      end
    end else begin
      for (int i = 0; i < 4; i++) begin
        if (rdEn && rdIdx == 2'(i) && clrM[i]) cntM[i] = refInc(selM[i]);
        else cntM[i] = cntM[i] + refInc(selM[i]);
      end
      if (cfgWe) begin
        selM[cfgIdx] = cfgSel;
        clrM[cfgIdx] = cfgClr;
      end
    end
  end

  // Random event traffic
  always @(negedge clk) begin
    if (evRun) begin
      evPulse     <= 6'($urandom);
      evOcc       <= 12'($urandom);
      quadIdxBusy <= 4'($urandom);
      quadRdBusy  <= 4'($urandom);
      for (int q = 0; q < 4; q++) begin
        quadBanks[3*q +: 3] <= 3'($urandom_range(0, 4));
        quadWdat[3*q +: 3]  <= 3'($urandom_range(0, 4));
      end
    end
  end

  task automatic doCfg(input logic [1:0] idx, input logic [7:0] code, input logic clr);
    @(negedge clk);
    cfgWe = 1'b1; cfgIdx = idx; cfgSel = code; cfgClr = clr;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic doRead(input logic [1:0] idx, input string req);
    expItem_t it;
    @(negedge clk);
    rdEn = 1'b1; rdIdx = idx;
    it.val = cntM[idx];
    it.req = req;
    expQ.push_back(it);
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: pops expected reads and compares
  always @(negedge clk) begin
    expItem_t it;
    if (rstN === 1'b1 && rdValid === 1'b1) begin
      total++;
      if (expQ.size() == 0) begin
        bad++;
        $display("FAIL R3: unexpected rdValid, actual data=%0h expected no read", rdData);
      end else begin
        it = expQ.pop_front();
        if (rdData !== it.val) begin
          bad++;
          $display("FAIL %s: rdData actual=%0d expected=%0d", it.req, rdData, it.val);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rstN = 1'b0; cfgWe = 1'b0; cfgIdx = '0; cfgSel = '0; cfgClr = 1'b0;
    rdEn = 1'b0; rdIdx = '0;
    evPulse = '0; evOcc = '0; quadIdxBusy = '0; quadRdBusy = '0; quadBanks = '0; quadWdat = '0;
    repeat (4) @(negedge clk);
    total++;
    if (rdValid !== 1'b0) begin
      bad++;
      $display("FAIL R2: rdValid in reset actual=%b expected=0", rdValid);
    end
    rstN = 1'b1;
    // R2: counters zero after reset
    for (int i = 0; i < 4; i++) doRead(2'(i), "R2");

    // R1: independent configuration of each counter
    doCfg(2'd0, 8'd1, 1'b0);
    doCfg(2'd1, 8'd2, 1'b0);
    doCfg(2'd2, 8'd8, 1'b0);
    doCfg(2'd3, 8'd162, 1'b0);
    evRun = 1'b1;
    idle(25);
    doRead(2'd0, "R5");
    doRead(2'd1, "R6");
    doRead(2'd2, "R7");
    doRead(2'd3, "R8");
    doRead(2'd0, "R9");   // no clear option: keeps counting
    doRead(2'd0, "R3");

    // R10: reconfiguration keeps the value; R4: code 0 and undefined codes idle
    doCfg(2'd1, 8'd0, 1'b0);
    doRead(2'd1, "R10");
    idle(10);
    doRead(2'd1, "R4");
    doCfg(2'd2, 8'd99, 1'b0);
    idle(10);
    doRead(2'd2, "R4");
    doCfg(2'd3, 8'd133, 1'b0);
    idle(10);
    doRead(2'd3, "R4");

    // R6: each pulse code
    for (int c = 2; c <= 7; c++) begin
      doCfg(2'd1, 8'(c), 1'b0);
      idle(8);
      doRead(2'd1, "R6");
    end
    // R7: remaining occupancy codes
    for (int c = 9; c <= 10; c++) begin
      doCfg(2'd2, 8'(c), 1'b0);
      idle(8);
      doRead(2'd2, "R7");
    end
    // R8: spread of quadrant codes
    begin
      logic [7:0] qc[6] = '{8'd128, 8'd145, 8'd179, 8'd147, 8'd176, 8'd130};
      for (int n = 0; n < 6; n++) begin
        doCfg(2'd3, qc[n], 1'b0);
        idle(8);
        doRead(2'd3, "R8");
      end
    end

    // R9: clear-on-read with concurrent increments; R10 on option change
    doCfg(2'd0, 8'd1, 1'b1);
    doRead(2'd0, "R10");
    idle(5);
    doRead(2'd0, "R9");
    doRead(2'd0, "R9");
    doCfg(2'd2, 8'd8, 1'b1);
    idle(6);
    doRead(2'd2, "R9");
    doRead(2'd2, "R9");
    doCfg(2'd1, 8'd0, 1'b1);
    doRead(2'd1, "R9");
    doRead(2'd1, "R9");

    // R1: final independent readback
    idle(7);
    for (int i = 0; i < 4; i++) doRead(2'(i), "R1");
    idle(3);
    total++;
    if (expQ.size() != 0) begin
      bad++;
      $display("FAIL R3: pending reads actual=%0d expected=0", expQ.size());
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule